// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel that copies a run of data words from a source region to a destination region through a plain read/write memory master port. Software presents a 24-bit source pointer, a 24-bit destination pointer, a 16-bit word count, a per-pointer stepping rule and a bus-holding mode, all on one strobe that also arms the channel. The channel waits for its external request line, asks for the bus, and when the bus is granted it performs one read at the source pointer followed by one write of that word at the destination pointer. After each write both pointers step by their own rules.

The bus-holding mode decides what happens between words. In single mode the channel gives the bus back after each word and asks for it again. In burst mode it keeps the bus while the request line stays high. In continuous mode it keeps the bus until the count runs out. When the last write is acknowledged the channel flags end of process for that cycle and raises a sticky interrupt. Software clears the interrupt with a separate input.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset, bus_req, mem_rd, mem_wr, eop and irq are all low.
- R2: prog_go loads every prog_* field and arms the channel only while the channel is idle. A prog_go that arrives during a run changes neither the pointers nor the count of that run.
- R3: Each transfer is one read cycle at the current source pointer, followed in the next cycle by one write at the current destination pointer. The write carries the data returned by that read.
- R4: After each acknowledged write, each pointer steps by its own 2-bit rule: 1 adds one, 2 subtracts one, and 0 or 3 leaves it unchanged. Arithmetic is modulo 2^AW.
- R5: A run performs exactly prog_cnt transfers. A count of zero performs 2^CW transfers.
- R6: In single mode (prog_mode 0), bus_req goes low after every transfer, so a run of N words takes N separate bus tenures.
- R7: In burst mode (prog_mode 1), the channel starts another transfer right away while dreq is high when a write completes. It drops bus_req when dreq is low at that point, and begins a new tenure when dreq returns.
- R8: In continuous mode (prog_mode 2), bus_req stays high from the first grant until the last transfer, whatever dreq does.
- R9: An armed channel raises bus_req only when dreq is high. It performs no memory access before bus_gnt is seen.
- R10: eop is high in exactly one cycle per run: the cycle in which the last write is acknowledged.
- R11: irq is set on the edge after eop and then stays high until irq_clr is sampled high. If completion and irq_clr happen on the same edge, irq is set.
- R12: prog_mode value 3 behaves exactly like single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_go | input | 1 | Load all prog_* fields and arm (honoured when idle) |
| prog_src | input | AW | Source start pointer |
| prog_dst | input | AW | Destination start pointer |
| prog_cnt | input | CW | Word count (0 means 2^CW) |
| prog_mode | input | 2 | 0 single, 1 burst, 2 continuous, 3 single |
| prog_src_step | input | 2 | Source step: 1 up, 2 down, 0/3 hold |
| prog_dst_step | input | 2 | Destination step: 1 up, 2 down, 0/3 hold |
| dreq | input | 1 | External transfer request |
| bus_req | output | 1 | Bus request / ownership |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data (valid with mem_ack) |
| mem_ack | input | 1 | Access acknowledge |
| eop | output | 1 | End of process, last write acknowledged |
| irq | output | 1 | Sticky completion interrupt |
| irq_clr | input | 1 | Clear irq |

## Verification
Two functions can land on the same edge. One is the completion that sets irq. The other is software clearing irq with irq_clr. The bench provokes this by raising irq_clr in the very cycle it sees eop. It then expects irq high on the following cycle, because the set wins, and low one cycle later, once the clear is seen alone. A second overlap comes from a burst run in which dreq falls in the same cycle a write is acknowledged. That release must cost exactly one extra bus tenure, which the bench counts.

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_go,
  input  logic [AW-1:0] prog_src,
  input  logic [AW-1:0] prog_dst,
  input  logic [CW-1:0] prog_cnt,
  input  logic [1:0]    prog_mode,
  input  logic [1:0]    prog_src_step,
  input  logic [1:0]    prog_dst_step,
  input  logic          dreq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          eop,
  output logic          irq,
  input  logic          irq_clr
);

  localparam logic [1:0] MODE_BURST = 2'd1;
  localparam logic [1:0] MODE_CONT  = 2'd2;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_REQ, S_RD, S_WR} state_t;

  state_t        state;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    mode_q, sstep_q, dstep_q;
  logic [DW-1:0] data_q;
  logic          irq_q;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] a, input logic [1:0] s);
    case (s)
      2'd1:    step_ptr = a + AW'(1);
      2'd2:    step_ptr = a - AW'(1);
      default: step_ptr = a;
    endcase
  endfunction

  wire last    = (cnt_q == CNT_ONE);
  wire wr_done = (state == S_WR) && mem_ack;
  wire is_cont = (mode_q == MODE_CONT);
  wire is_bst  = (mode_q == MODE_BURST);

  assign bus_req   = (state == S_REQ) || (state == S_RD) || (state == S_WR);
  assign mem_rd    = (state == S_RD);
  assign mem_wr    = (state == S_WR);
  assign mem_addr  = mem_wr ? dst_q : (mem_rd ? src_q : '0);
  assign mem_wdata = data_q;
  assign eop       = wr_done && last;
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      mode_q  <= '0;
      sstep_q <= '0;
      dstep_q <= '0;
      data_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (prog_go) begin
          src_q   <= prog_src;
          dst_q   <= prog_dst;
          cnt_q   <= prog_cnt;
          mode_q  <= prog_mode;
          sstep_q <= prog_src_step;
          dstep_q <= prog_dst_step;
          state   <= S_ARMED;
        end
        S_ARMED: if (dreq) state <= S_REQ;
        S_REQ:   if (bus_gnt) state <= S_RD;
        S_RD: if (mem_ack) begin
          data_q <= mem_rdata;
          state  <= S_WR;
        end
        S_WR: if (mem_ack) begin
          src_q <= step_ptr(src_q, sstep_q);
          dst_q <= step_ptr(dst_q, dstep_q);
          cnt_q <= cnt_q - CNT_ONE;
          if (last)                 state <= S_IDLE;
          else if (is_cont)         state <= S_RD;
          else if (is_bst && dreq)  state <= S_RD;
          else                      state <= S_ARMED;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (eop)     irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  AST_ACCESS_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_gnt); // R9
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ack) |=> mem_wr); // R3
  AST_HOLD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && (sstep_q == 2'd0 || sstep_q == 2'd3)) |=> $stable(src_q)); // R4
  AST_BUSY_IGNORES_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && prog_go && !wr_done) |=> $stable(src_q) && $stable(cnt_q)); // R2
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !is_bst && !is_cont) |=> !bus_req); // R6
  AST_BURST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !last && is_bst && !dreq) |=> !bus_req); // R7
  AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !last && is_cont) |=> mem_rd); // R8
  AST_EOP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> (mem_wr && mem_ack)); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> (irq && !bus_req)); // R11
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R11

endmodule

// File: tb/test_dma_xfer_chan.sv
`timescale 1ns/1ps
module test_dma_xfer_chan;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic prog_go = 1'b0;
  logic [AW-1:0] prog_src = '0, prog_dst = '0;
  logic [CW-1:0] prog_cnt = '0;
  logic [1:0] prog_mode = '0, prog_src_step = '0, prog_dst_step = '0;
  logic dreq = 1'b0;
  logic bus_req, bus_gnt;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, mem_ack, eop, irq;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic irq_clr = 1'b0;

  dma_xfer_chan #(.AW(AW), .DW(DW), .CW(CW)) i_dma_xfer_chan (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_src(prog_src), .prog_dst(prog_dst),
    .prog_cnt(prog_cnt), .prog_mode(prog_mode), .prog_src_step(prog_src_step),
    .prog_dst_step(prog_dst_step), .dreq(dreq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .eop(eop), .irq(irq), .irq_clr(irq_clr));

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    pat = a[DW-1:0] ^ 16'h5A3C ^ DW'(a[AW-1:AW-8]);
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [1:0] s);
    if (s == 2'd1) nxt = a + AW'(1);
    else if (s == 2'd2) nxt = a - AW'(1);
    else nxt = a;
  endfunction

  assign mem_ack   = mem_rd | mem_wr;
  assign mem_rdata = pat(mem_addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_gnt <= 1'b0; else bus_gnt <= bus_req;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_src, exp_dst, rd_addr;
  logic [1:0] ss_m, ds_m;
  int wcnt, tenures, eops, eop_bad, addr_err, data_err, gnt_err, drop_at, low_left, n_exp;
  bit collide, prev_req;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_req && !prev_req) tenures++;
    prev_req = bus_req;
    if ((mem_rd || mem_wr) && !bus_gnt) gnt_err++;
    if (mem_rd && mem_ack) begin
      if (mem_addr != exp_src) addr_err++;
      rd_addr = mem_addr;
    end
    if (low_left > 0) begin
      low_left--;
      if (low_left == 0) dreq = 1'b1;
    end
    if (mem_wr && mem_ack) begin
      if (mem_addr != exp_dst) addr_err++;
      if (mem_wdata != pat(rd_addr)) data_err++;
      exp_src = nxt(exp_src, ss_m);
      exp_dst = nxt(exp_dst, ds_m);
      wcnt++;
      if (wcnt == drop_at) begin
        dreq = 1'b0;
        low_left = 3;
      end
    end
    if (eop) begin
      eops++;
      if (wcnt != n_exp) eop_bad++;
      if (collide) irq_clr = 1'b1;
    end
  end

  task automatic run(input logic [1:0] m, input logic [AW-1:0] s, input logic [AW-1:0] d,
                     input logic [1:0] ss, input logic [1:0] ds, input logic [CW-1:0] c,
                     input int drop, input bit coll, input bit mid_go, input bit start_low);
    int exp_ten, t;
    string mt;
    @(negedge clk);
    n_exp = (c == 0) ? (1 << CW) : int'(c);
    exp_src = s; exp_dst = d; ss_m = ss; ds_m = ds;
    wcnt = 0; tenures = 0; eops = 0; eop_bad = 0; addr_err = 0; data_err = 0; gnt_err = 0;
    drop_at = drop; low_left = 0; collide = coll;
    dreq = !start_low;
    prog_src = s; prog_dst = d; prog_cnt = c; prog_mode = m;
    prog_src_step = ss; prog_dst_step = ds; prog_go = 1'b1;
    @(negedge clk);
    prog_go = 1'b0;
    if (start_low) begin
      repeat (8) @(negedge clk);
      check(!bus_req && !mem_rd && !mem_wr, "R9 no request without dreq", bus_req, 0);
      dreq = 1'b1;
    end
    if (mid_go) begin
      repeat (3) @(negedge clk);
      prog_src = ~s; prog_dst = ~d; prog_cnt = c + CW'(3); prog_go = 1'b1;
      @(negedge clk);
      prog_go = 1'b0;
    end
    t = 0;
    while (!irq && t < 2000) begin @(negedge clk); t++; end
    check(t < 2000, "R5 run completes", t, 0);
    if (coll) begin
      check(irq == 1'b1, "R11 set wins over clear", irq, 1);
      @(negedge clk);
      irq_clr = 1'b0;
      check(irq == 1'b0, "R11 clear after collision", irq, 0);
    end else begin
      repeat (3) @(negedge clk);
      check(irq == 1'b1, "R11 irq sticky", irq, 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check(irq == 1'b0, "R11 irq cleared", irq, 0);
    end
    if (m == 2'd1) begin exp_ten = (drop > 0 && drop < n_exp) ? 2 : 1; mt = "R7 burst tenures"; end
    else if (m == 2'd2) begin exp_ten = 1; mt = "R8 continuous tenures"; end
    else if (m == 2'd3) begin exp_ten = n_exp; mt = "R12 reserved-as-single tenures"; end
    else begin exp_ten = n_exp; mt = "R6 single tenures"; end
    check(wcnt == n_exp, "R5 transfer count", wcnt, n_exp);
    check(addr_err == 0, mid_go ? "R2 busy prog_go ignored" : "R4 pointer sequence", addr_err, 0);
    check(data_err == 0, "R3 read data copied", data_err, 0);
    check(gnt_err == 0, "R9 access only with grant", gnt_err, 0);
    check(tenures == exp_ten, mt, tenures, exp_ten);
    check(eops == 1 && eop_bad == 0, "R10 single eop on last write", eops, 1);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_req && !mem_rd && !mem_wr && !eop && !irq, "R1 reset state",
          {bus_req, mem_rd, mem_wr, eop, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_req && !irq, "R1 idle after reset", {bus_req, irq}, 0);
    for (int m = 0; m < 4; m++)
      for (int ss = 0; ss < 4; ss++)
        for (int ds = 0; ds < 4; ds++)
          run(2'(m), AW'(24'h100000 * m + 24'h40 * ss + 24'h8), AW'(24'h800000 + 24'h100 * ds),
              2'(ss), 2'(ds), CW'(1 + ((ss * 4 + ds + m) % 6)), 2, 1'b0, 1'b0, 1'b0);
    run(2'd2, 24'hFFFFFE, 24'h000001, 2'd1, 2'd2, '0, 3, 1'b0, 1'b0, 1'b0);
    run(2'd0, 24'h123456, 24'h654321, 2'd1, 2'd1, '0, 0, 1'b0, 1'b0, 1'b0);
    run(2'd1, 24'h000100, 24'h000200, 2'd1, 2'd1, 4'd9, 0, 1'b0, 1'b0, 1'b0);
    run(2'd1, 24'h000300, 24'h000400, 2'd2, 2'd1, 4'd7, 4, 1'b0, 1'b0, 1'b0);
    run(2'd2, 24'h00A000, 24'h00B000, 2'd1, 2'd1, 4'd8, 0, 1'b0, 1'b1, 1'b0);
    run(2'd1, 24'h00C000, 24'h00D000, 2'd1, 2'd2, 4'd5, 2, 1'b1, 1'b0, 1'b0);
    run(2'd0, 24'h00E000, 24'h00F000, 2'd1, 2'd1, 4'd2, 0, 1'b0, 1'b0, 1'b1);
    finish_up();
  end
endmodule